// File: doc/BRIEF.md
# Interleaved Multi-Stream Accumulator Engine

This block runs one accumulate-and-lookup loop for several independent data streams by time sharing. Each stream keeps a running sum and a small private table. When a sample arrives, the stream looks up the table entry selected by the low bits of the sample. The new sum is the old sum plus the sample plus that entry, and the new sum is then written back into the same entry. The loop's state register is stretched into a chain of `C` registers, and the table is banked by stream, so `C` streams share one datapath. A stream's state comes back to the adder exactly `C` cycles after it left.

A round-robin interleaver picks one stream per clock from a set of per-stream inputs. A matching deinterleaver steers each result to that stream's own output register. Each stream is served once every `C` cycles. Across all streams the engine still accepts one sample per clock.

Top module: `cs_stream_engine`

## Requirements
- R1: A slot counter steps 0,1,…,C-1,0,… on every clock. The first clock edge after reset is slot 0. Stream k's inputs are sampled only on edges in slot k.
- R2: For a sampled valid input x on stream k, let e be the unsigned value of x's low TAW bits and T_k[e] the table entry. The new sum is S_k + x + T_k[e] modulo 2^W. That new sum is then stored both as S_k and as T_k[e].
- R3: Synchronous active-high reset sets every stream's sum to zero. After reset, every table entry reads as zero until it is written.
- R4: When stream k's valid bit is low in its slot, its sum, its table and its output stay unchanged, and its update pulse stays low.
- R5: A clear bit that is high in stream k's slot sets S_k to zero and makes all of T_k read as zero. It overrides a valid sample in the same slot. The clear produces an update pulse with result zero.
- R6: A sample or clear taken at clock edge E sets out_result for that stream and raises bit k of out_upd after edge E+2. The pulse lasts one cycle, and at most one out_upd bit is high at a time.
- R7: out_result for stream k changes only in a cycle where out_upd[k] is high.
- R8: Activity on one stream, including clears, never changes another stream's sum, table or output.
- R9: Lane k of each packed bus is bits [k*XW +: XW] for in_data and bits [k*W +: W] for out_result. Bit k of in_valid, in_clear and out_upd belongs to stream k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | C | Per-stream sample present |
| in_clear | input | C | Per-stream clear request |
| in_data | input | C*XW | Per-stream sample values, packed by lane |
| out_result | output | C*W | Per-stream latest sum, packed by lane |
| out_upd | output | C | Per-stream one-cycle update pulse |

## Verification
The assertions assume that reset is held for at least one edge before normal operation, so the slot counter and the result pipeline start from a known state. They relate the pulse to the slot counter and assume no reset occurs inside the two-cycle result window. The stimulus meets these assumptions: it only ever asserts reset across whole cycles and restarts its reference model each time. The stimulus also holds per-stream inputs steady from one falling edge to the next, so the value the engine samples in a slot is always the value the model used.

// File: rtl/cs_pkg.sv
`timescale 1ns/1ps
package cs_pkg;
  // Round-robin successor of a slot index.
  function automatic int unsigned slot_next(input int unsigned cur, input int unsigned count);
    return (cur + 1 >= count) ? 0 : cur + 1;
  endfunction
endpackage

// File: rtl/cs_interleaver.sv
`timescale 1ns/1ps
module cs_interleaver #(
  parameter int C  = 4,
  parameter int XW = 8,
  parameter int SW = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [C-1:0]    in_valid,
  input  logic [C-1:0]    in_clear,
  input  logic [C*XW-1:0] in_data,
  output logic [SW-1:0]   slot,
  output logic            beat_valid,
  output logic            beat_clear,
  output logic [XW-1:0]   beat_data
);
  import cs_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) slot <= '0;
    else     slot <= SW'(slot_next(int'(slot), C));
  end

  always_comb begin
    beat_valid = in_valid[slot];
    beat_clear = in_clear[slot];
    beat_data  = in_data[int'(slot)*XW +: XW];
  end
endmodule

// File: rtl/cs_bank_ram.sv
`timescale 1ns/1ps
module cs_bank_ram #(
  parameter int DW = 16,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/cs_core.sv
`timescale 1ns/1ps
module cs_core #(
  parameter int C   = 4,
  parameter int XW  = 8,
  parameter int W   = 16,
  parameter int TAW = 3,
  parameter int SW  = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] slot,
  input  logic          beat_valid,
  input  logic          beat_clear,
  input  logic [XW-1:0] beat_data,
  output logic [W-1:0]  res_data,
  output logic [SW-1:0] res_slot,
  output logic          res_upd
);
  localparam int D   = 1 << TAW;
  localparam int RAW = SW + TAW;
  localparam int NE  = 1 << RAW;

  logic [SW-1:0]  s1;
  logic           v1, c1, hit1;
  logic [XW-1:0]  x1;
  logic [W-1:0]   rd1, m1, acc_old, acc_new;
  logic [RAW-1:0] raddr, waddr;
  logic [NE-1:0]  written;
  logic [W-1:0]   chain [C];

  assign raddr = {slot, beat_data[TAW-1:0]};
  assign waddr = {s1, x1[TAW-1:0]};

  // stage 1 capture; table read runs in parallel
  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '0; v1 <= 1'b0; c1 <= 1'b0; x1 <= '0; hit1 <= 1'b0;
    end else begin
      s1   <= slot;
      v1   <= beat_valid;
      c1   <= beat_clear;
      x1   <= beat_data;
      hit1 <= written[raddr];
    end
  end

  cs_bank_ram #(.DW(W), .AW(RAW)) u_ram (
    .clk  (clk),
    .we   (v1 && !c1),
    .waddr(waddr),
    .wdata(acc_new),
    .raddr(raddr),
    .rdata(rd1)
  );

  // entry-written flags give zero reads after reset or clear
  always_ff @(posedge clk) begin
    if (rst) written <= '0;
    else if (c1) begin
      for (int j = 0; j < D; j++) written[int'(s1)*D + j] <= 1'b0;
    end else if (v1) written[waddr] <= 1'b1;
  end

  // loop body: held value recirculates when idle
  always_comb begin
    m1      = hit1 ? rd1 : '0;
    acc_old = chain[C-1];
    if (c1)      acc_new = '0;
    else if (v1) acc_new = acc_old + W'(x1) + m1;
    else         acc_new = acc_old;
  end

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= acc_new;
  end

  for (genvar i = 1; i < C; i++) begin : g_chain
    always_ff @(posedge clk) begin
      if (rst) chain[i] <= '0;
      else     chain[i] <= chain[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_slot <= '0; res_upd <= 1'b0;
    end else begin
      res_slot <= s1;
      res_upd  <= v1 | c1;
    end
  end

  assign res_data = chain[0];
endmodule

// File: rtl/cs_deinterleaver.sv
`timescale 1ns/1ps
module cs_deinterleaver #(
  parameter int C  = 4,
  parameter int W  = 16,
  parameter int SW = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [W-1:0]   res_data,
  input  logic [SW-1:0]  res_slot,
  input  logic           res_upd,
  output logic [C*W-1:0] out_result,
  output logic [C-1:0]   out_upd
);
  for (genvar k = 0; k < C; k++) begin : g_lane
    logic hit;
    assign hit = res_upd && (int'(res_slot) == k);
    always_ff @(posedge clk) begin
      if (rst) begin
        out_result[k*W +: W] <= '0;
        out_upd[k]           <= 1'b0;
      end else begin
        out_upd[k] <= hit;
        if (hit) out_result[k*W +: W] <= res_data;
      end
    end
  end
endmodule

// File: rtl/cs_stream_engine.sv
`timescale 1ns/1ps
module cs_stream_engine #(
  parameter int C   = 4,
  parameter int XW  = 8,
  parameter int W   = 16,
  parameter int TAW = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [C-1:0]   in_valid,
  input  logic [C-1:0]   in_clear,
  input  logic [C*XW-1:0] in_data,
  output logic [C*W-1:0] out_result,
  output logic [C-1:0]   out_upd
);
  localparam int SW = (C > 1) ? $clog2(C) : 1;

  logic [SW-1:0] slot, res_slot;
  logic          beat_valid, beat_clear, res_upd;
  logic [XW-1:0] beat_data;
  logic [W-1:0]  res_data;

  cs_interleaver #(.C(C), .XW(XW), .SW(SW)) u_ilv (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_clear(in_clear),
    .in_data(in_data), .slot(slot), .beat_valid(beat_valid),
    .beat_clear(beat_clear), .beat_data(beat_data)
  );

  cs_core #(.C(C), .XW(XW), .W(W), .TAW(TAW), .SW(SW)) u_core (
    .clk(clk), .rst(rst), .slot(slot), .beat_valid(beat_valid),
    .beat_clear(beat_clear), .beat_data(beat_data),
    .res_data(res_data), .res_slot(res_slot), .res_upd(res_upd)
  );

  cs_deinterleaver #(.C(C), .W(W), .SW(SW)) u_dil (
    .clk(clk), .rst(rst), .res_data(res_data), .res_slot(res_slot),
    .res_upd(res_upd), .out_result(out_result), .out_upd(out_upd)
  );
endmodule

// File: rtl/cs_checker.sv
`timescale 1ns/1ps
module cs_checker #(
  parameter int C  = 4,
  parameter int W  = 16,
  parameter int SW = 2
) (
  input logic           clk,
  input logic           rst,
  input logic [SW-1:0]  slot,
  input logic [C-1:0]   out_upd,
  input logic [C*W-1:0] out_result
);
  // R1
  slot_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> int'(slot) == ((int'($past(slot)) + 1) % C));

  // R6
  upd_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(out_upd));

  // R6
  upd_lag_chk: assert property (@(posedge clk) disable iff (rst)
    (out_upd != '0) |-> out_upd[(int'(slot) + 3*C - 3) % C]);

  // R3
  reset_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (out_result == '0 && out_upd == '0));

  for (genvar k = 0; k < C; k++) begin : g_hold
    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
      !out_upd[k] |-> $stable(out_result[k*W +: W]));
  end
endmodule

bind cs_stream_engine cs_checker #(.C(C), .W(W), .SW(SW)) u_chk (
  .clk(clk), .rst(rst), .slot(slot), .out_upd(out_upd), .out_result(out_result)
);

// File: tb/cs_stream_engine_bench.sv
`timescale 1ns/1ps
module cs_stream_engine_bench;
  localparam int C = 4, XW = 8, W = 16, TAW = 3, D = 1 << TAW;

  logic clk = 1'b0, rst = 1'b1;
  logic [C-1:0] in_valid = '0, in_clear = '0;
  logic [C*XW-1:0] in_data = '0;
  logic [C*W-1:0] out_result;
  logic [C-1:0] out_upd;

  always #5 clk = ~clk;

  cs_stream_engine #(.C(C), .XW(XW), .W(W), .TAW(TAW)) u_cs_stream_engine (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_clear(in_clear),
    .in_data(in_data), .out_result(out_result), .out_upd(out_upd)
  );

  int checks = 0, errors = 0;
  logic [W-1:0] acc_m [C];
  logic [W-1:0] tbl [C][D];
  logic [W-1:0] exp_res [C];
  logic [C-1:0] exp_upd;
  int q_s[$], q_u[$];
  logic [W-1:0] q_v[$];
  int bslot;
  string tag;
  bit done = 0;

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < C; k++) begin
      acc_m[k] = '0; exp_res[k] = '0;
      for (int e = 0; e < D; e++) tbl[k][e] = '0;
    end
    exp_upd = '0; bslot = 0;
    q_s.delete(); q_u.delete(); q_v.delete();
    for (int i = 0; i < 2; i++) begin q_s.push_back(0); q_u.push_back(0); q_v.push_back('0); end
  endtask

  task automatic do_reset();
    rst = 1'b1; in_valid = '0; in_clear = '0;
    repeat (3) @(negedge clk);
    check("R3", W'(out_upd), '0, "upd in reset");
    for (int k = 0; k < C; k++) check("R3", out_result[k*W +: W], '0, "result in reset");
    rst = 1'b0;
    model_reset();
  endtask

  // one clock: model the edge, then compare after it
  task automatic cycle();
    int k, e, u;
    logic [W-1:0] v;
    logic [XW-1:0] x;
    @(posedge clk);
    k = bslot; u = 0; v = '0;
    x = in_data[k*XW +: XW];
    e = int'(x[TAW-1:0]);
    if (in_clear[k]) begin
      acc_m[k] = '0; for (int j = 0; j < D; j++) tbl[k][j] = '0;
      u = 1; v = '0;
    end else if (in_valid[k]) begin
      acc_m[k] = acc_m[k] + W'(x) + tbl[k][e];
      tbl[k][e] = acc_m[k];
      u = 1; v = acc_m[k];
    end
    q_s.push_back(k); q_u.push_back(u); q_v.push_back(v);
    bslot = (bslot + 1) % C;
    @(negedge clk);
    k = q_s.pop_front(); u = q_u.pop_front(); v = q_v.pop_front();
    exp_upd = '0;
    if (u != 0) begin exp_upd[k] = 1'b1; exp_res[k] = v; end
    check("R6", W'(out_upd), W'(exp_upd), "update pulse");
    for (int j = 0; j < C; j++) check(tag, out_result[j*W +: W], exp_res[j], "lane result");
  endtask

  // mode: 0 random, 1 lane1 idle, 2 hammer one entry, 3 clears, 4 lane0 clears only,
  //       5 only lane2 active, 6 sparse
  task automatic drive(input int mode);
    for (int k = 0; k < C; k++) begin
      logic [XW-1:0] x;
      x = XW'($urandom);
      in_valid[k] = ($urandom % 10) < 7;
      in_clear[k] = ($urandom % 33) == 0;
      case (mode)
        1: if (k == 1) begin in_valid[k] = 1'b0; in_clear[k] = 1'b0; end
        2: begin x[TAW-1:0] = TAW'(5); in_clear[k] = 1'b0; end
        3: in_clear[k] = ($urandom % 4) == 0;
        4: in_clear[k] = (k == 0) && (($urandom % 3) == 0);
        5: begin in_valid[k] = (k == 2); in_clear[k] = 1'b0; end
        6: begin in_valid[k] = ($urandom % 10) == 0; in_clear[k] = 1'b0; end
        default: ;
      endcase
      in_data[k*XW +: XW] = x;
    end
  endtask

  task automatic phase(input string t, input int mode, input int n);
    tag = t;
    for (int i = 0; i < n; i++) begin drive(mode); cycle(); end
  endtask

  initial begin
    tag = "R2";
    do_reset();
    phase("R1", 5, 200);
    phase("R2", 0, 600);
    phase("R4", 1, 400);
    phase("R2", 2, 300);
    phase("R5", 3, 400);
    phase("R8", 4, 400);
    phase("R7", 6, 300);
    do_reset();
    phase("R3", 2, 200);
    phase("R9", 0, 200);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule